// File: doc/BRIEF.md
# Registered DIMM power-up sequencer

This controller-side block takes a registered DDR memory module from power-on to the point where the normal DDR initialization may begin. It owns the module's asynchronous register reset, the CKE pin and the command/address pins. The pins stay quiet until the controller clock is known to be stable and fast enough. The block then times the module PLL settling interval and the DRAM clock settling interval. It places a defined pattern on the register inputs, lifts the register reset and waits out the register activation time. Finally it hands over to the DDR initializer with a one-cycle start pulse.

All intervals are counted in controller cycles. `CLK_PER_US` scales the microsecond waits (`PLL_US`, `DRAM_US`), and `T_ACT_CYC` gives the register activation time directly in cycles. `IDLE_NOP` chooses the pattern held on the register inputs around the reset release. The system reset `rst_n` is active low and asynchronous. The clock qualification inputs are treated as synchronous to `clk`.

Top module: `rdimm_pwrup_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the outputs are `mod_rst_n`=0, `cke`=0, `busy`=1, `init_start`=0, and `cs_n`, `ras_n`, `cas_n`, `we_n` and `addr` are all 0.
- R2: If `clk_stable` and `freq_ok` are never high in the same cycle, `mod_rst_n` stays low and `busy` stays high indefinitely.
- R3: Take the first rising clock edge at which both qualification inputs are high, and call it edge 1. `mod_rst_n` goes high right after edge PLL_US*CLK_PER_US + DRAM_US*CLK_PER_US + 2.
- R4: If either qualification input is low at an edge during the PLL or DRAM settling wait, the block returns to waiting for the clock with `mod_rst_n` low. The full wait of R3 is then counted again from the next qualified edge.
- R5: With `IDLE_NOP`=1, the cycle before the reset release and every cycle up to and including the `init_start` cycle show `cs_n`=`ras_n`=`cas_n`=`we_n`=1 and `addr`=0.
- R6: With `IDLE_NOP`=0, the same cycles show `cs_n`, `ras_n`, `cas_n`, `we_n` and `addr` all 0.
- R7: The command and address pins do not change from the cycle before the reset release through the `init_start` cycle.
- R8: `init_start` is high for exactly one cycle. It rises right after the edge T_ACT_CYC edges after the one that raised `mod_rst_n`.
- R9: `busy` falls in the cycle right after the `init_start` cycle and stays low until the next system reset. In that done state, `cke`=1, the pins show the deselect pattern (`cs_n`=`ras_n`=`cas_n`=`we_n`=1, `addr`=0) and `mod_rst_n`=1.
- R10: Once `mod_rst_n` is high, dropping the qualification inputs has no effect on the timing of `init_start` or on any output.
- R11: `cke` is low in every cycle in which `mod_rst_n` is low or `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| clk_stable | input | 1 | Module clock has settled |
| freq_ok | input | 1 | Module clock is at or above the PLL minimum frequency |
| mod_rst_n | output | 1 | Module register reset, active low |
| cke | output | 1 | Clock enable to the DRAMs |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| busy | output | 1 | Power-up sequence still running |
| init_start | output | 1 | One-cycle pulse that starts the DDR initialization |

## Verification
The sequence is run with both qualification inputs held high from one edge onward, which gives the exact cycle counts for the reset release and the start pulse. The same run is made with each of the two idle patterns, to tell the two input-pattern modes apart. Runs where only one qualification input is high show that a half-qualified clock never starts the waits. One-cycle drops during the PLL wait and during the DRAM wait each show that the wait restarts in full rather than resuming. A drop after the reset release shows that the activation wait and the handoff ignore the clock flags.

// File: rtl/rdimm_pwrup_seq.sv
module rdimm_pwrup_seq #(
  parameter int CLK_PER_US = 125,
  parameter int PLL_US     = 100,
  parameter int DRAM_US    = 200,
  parameter int T_ACT_CYC  = 16,
  parameter int ADDR_W     = 13,
  parameter bit IDLE_NOP   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_stable,
  input  logic              freq_ok,
  output logic              mod_rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              init_start
);

  localparam int PLL_CYC  = PLL_US * CLK_PER_US;
  localparam int DRAM_CYC = DRAM_US * CLK_PER_US;
  localparam int MAX_A    = (PLL_CYC > DRAM_CYC) ? PLL_CYC : DRAM_CYC;
  localparam int MAX_CYC  = (MAX_A > T_ACT_CYC) ? MAX_A : T_ACT_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_CYC - 1);
  localparam logic [CW-1:0] DRAM_LAST = CW'(DRAM_CYC - 1);
  localparam logic [CW-1:0] ACT_LAST  = CW'(T_ACT_CYC - 1);

  typedef enum logic [2:0] {
    S_CLKWAIT, S_PLL, S_DRAM, S_SETUP, S_ACT, S_START, S_DONE
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          qual;
  logic          hold_pat;
  logic [3:0]    cmd;

  assign qual = clk_stable & freq_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_CLKWAIT;
      cnt   <= '0;
    end else begin
      case (state)
        S_CLKWAIT: begin
          cnt <= '0;
          if (qual) state <= S_PLL;
        end
        S_PLL: begin
          if (!qual) begin
            state <= S_CLKWAIT;
            cnt   <= '0;
          end else if (cnt == PLL_LAST) begin
            state <= S_DRAM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DRAM: begin
          if (!qual) begin
            state <= S_CLKWAIT;
            cnt   <= '0;
          end else if (cnt == DRAM_LAST) begin
            state <= S_SETUP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SETUP: begin
          state <= S_ACT;
          cnt   <= '0;
        end
        S_ACT: begin
          if (cnt == ACT_LAST) begin
            state <= S_START;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_START: state <= S_DONE;
        default: state <= S_DONE;
      endcase
    end
  end

  assign hold_pat   = (state == S_SETUP) || (state == S_ACT) || (state == S_START);
  assign mod_rst_n  = (state == S_ACT) || (state == S_START) || (state == S_DONE);
  assign cke        = (state == S_DONE);
  assign busy       = (state != S_DONE);
  assign init_start = (state == S_START);

  always_comb begin
    if (state == S_DONE)
      cmd = 4'b1111;
    else if (hold_pat && IDLE_NOP)
      cmd = 4'b1111;
    else
      cmd = 4'b0000;
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign addr = '0;

  assert_cke_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_rst_n || busy) |-> !cke);

  assert_no_drift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_ACT) || (state == S_START)) |-> $stable({cs_n, ras_n, cas_n, we_n, addr}));

  assert_release_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst_n) |-> $stable({cs_n, ras_n, cas_n, we_n, addr}));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((state == S_PLL) || (state == S_DRAM)) && !qual) |=> (state == S_CLKWAIT && !mod_rst_n));

  assert_pulse_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (!init_start && !busy));

  assert_start_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |-> $past(mod_rst_n));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!busy && mod_rst_n && cke));

  assert_release_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_n |=> mod_rst_n);

  assert_no_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_CLKWAIT) && !qual) |=> (state == S_CLKWAIT));

endmodule

// File: tb/sim_rdimm_pwrup_seq.sv
module sim_rdimm_pwrup_seq;
  localparam int CPU   = 2;
  localparam int TACT  = 5;
  localparam int AW    = 13;
  localparam int PLLC  = 100 * CPU;
  localparam int DRAMC = 200 * CPU;
  localparam int REL   = PLLC + DRAMC + 2;
  localparam int INIT  = REL + TACT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_stable = 1'b0;
  logic freq_ok = 1'b0;

  logic mr0, ck0, cs0, ra0, ca0, we0, bz0, is0;
  logic mr1, ck1, cs1, ra1, ca1, we1, bz1, is1;
  logic [AW-1:0] ad0, ad1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rdimm_pwrup_seq #(.CLK_PER_US(CPU), .T_ACT_CYC(TACT), .ADDR_W(AW), .IDLE_NOP(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .freq_ok(freq_ok),
    .mod_rst_n(mr0), .cke(ck0), .cs_n(cs0), .ras_n(ra0), .cas_n(ca0), .we_n(we0),
    .addr(ad0), .busy(bz0), .init_start(is0));

  rdimm_pwrup_seq #(.CLK_PER_US(CPU), .T_ACT_CYC(TACT), .ADDR_W(AW), .IDLE_NOP(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .freq_ok(freq_ok),
    .mod_rst_n(mr1), .cke(ck1), .cs_n(cs1), .ras_n(ra1), .cas_n(ca1), .we_n(we1),
    .addr(ad1), .busy(bz1), .init_start(is1));

  wire [AW+3:0] cmd0 = {cs0, ra0, ca0, we0, ad0};
  wire [AW+3:0] cmd1 = {cs1, ra1, ca1, we1, ad1};
  localparam logic [AW+3:0] PAT_NOP = {4'b1111, {AW{1'b0}}};
  localparam logic [AW+3:0] PAT_LOW = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clk_stable = 1'b0;
    freq_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Raises both flags, counts edges from 1, optionally drops flags after edge drop_at.
  task automatic measure(input int drop_at, output int rel, output int ini,
                         output int pulses, output bit pat_ok, output bit cke_ok,
                         output int busy_fall);
    logic [AW+3:0] pre0, pre1;
    rel = 0; ini = 0; pulses = 0; pat_ok = 1'b1; cke_ok = 1'b1; busy_fall = 0;
    pre0 = cmd0; pre1 = cmd1;
    clk_stable = 1'b1;
    freq_ok = 1'b1;
    for (int n = 1; n <= INIT + 4; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == drop_at) begin
        clk_stable = 1'b0;
        freq_ok = 1'b0;
      end
      if (rel == 0 && mr0) begin
        rel = n;
        if (pre0 != PAT_NOP || pre1 != PAT_LOW) pat_ok = 1'b0;
      end
      if (mr0 && bz0 && (cmd0 != PAT_NOP || cmd1 != PAT_LOW)) pat_ok = 1'b0;
      if ((!mr0 || bz0) && (ck0 || ck1)) cke_ok = 1'b0;
      if (is0) begin
        pulses++;
        if (ini == 0) ini = n;
      end
      if (busy_fall == 0 && !bz0) busy_fall = n;
      pre0 = cmd0;
      pre1 = cmd1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    clk_stable = 1'b1;
    freq_ok = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mr0 && !ck0 && bz0 && !is0 && cmd0 == 0, "R1", {mr0, ck0, bz0, is0}, 4'b0010);
    chk(!mr1 && !ck1 && bz1 && !is1 && cmd1 == 0, "R1", {mr1, ck1, bz1, is1}, 4'b0010);
    clk_stable = 1'b0;
    freq_ok = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mr0 && bz0 && cmd0 == 0, "R1", cmd0, 0);
  endtask

  task automatic t_no_qual();
    do_reset();
    clk_stable = 1'b1;
    repeat (REL + 20) @(negedge clk);
    chk(!mr0 && bz0, "R2", mr0, 0);
    clk_stable = 1'b0;
    freq_ok = 1'b1;
    repeat (REL + 20) @(negedge clk);
    chk(!mr0 && bz0 && !ck0, "R2", mr0, 0);
    freq_ok = 1'b0;
  endtask

  task automatic t_nominal();
    int rel, ini, pulses, bf;
    bit pat_ok, cke_ok;
    do_reset();
    measure(0, rel, ini, pulses, pat_ok, cke_ok, bf);
    chk(rel == REL, "R3", rel, REL);
    chk(mr1 == mr0, "R3", mr1, mr0);
    chk(pat_ok, "R5", pat_ok, 1);
    chk(pat_ok, "R6", pat_ok, 1);
    chk(pat_ok, "R7", pat_ok, 1);
    chk(ini == INIT, "R8", ini, INIT);
    chk(pulses == 1, "R8", pulses, 1);
    chk(bf == INIT + 1, "R9", bf, INIT + 1);
    chk(cke_ok, "R11", cke_ok, 1);
    chk(ck0 && mr0 && cmd0 == PAT_NOP && cmd1 == PAT_NOP, "R9", cmd1, PAT_NOP);
    clk_stable = 1'b0;
    freq_ok = 1'b0;
    repeat (20) @(negedge clk);
    chk(!bz0 && ck0 && !is0 && !bz1, "R9", bz0, 0);
  endtask

  task automatic t_drop(input int at);
    int rel, ini, pulses, bf;
    bit pat_ok, cke_ok;
    do_reset();
    clk_stable = 1'b1;
    freq_ok = 1'b1;
    repeat (at) @(negedge clk);
    freq_ok = 1'b0;
    @(negedge clk);
    freq_ok = 1'b1;
    clk_stable = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mr0 && bz0, "R4", mr0, 0);
    measure(0, rel, ini, pulses, pat_ok, cke_ok, bf);
    chk(rel == REL, "R4", rel, REL);
    chk(ini == INIT && cke_ok, "R4", ini, INIT);
  endtask

  task automatic t_late_drop();
    int rel, ini, pulses, bf;
    bit pat_ok, cke_ok;
    do_reset();
    measure(REL + 1, rel, ini, pulses, pat_ok, cke_ok, bf);
    chk(rel == REL, "R10", rel, REL);
    chk(ini == INIT && pulses == 1, "R10", ini, INIT);
    chk(pat_ok && mr0 && !bz0, "R10", pat_ok, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_no_qual();
        t_nominal();
        t_drop(50);
        t_drop(PLLC + 30);
        t_late_drop();
      end
      begin
        wait (cyc >= 150000);
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule